// File: doc/BRIEF.md
# Master-Receive Status Sequencer

This block keeps the status flags and interrupt lines of a serial-bus controller while that controller runs a transaction as master receiver. Software starts the transaction with a command write. The bit-level engine then reports abstract events: the arbitration outcome, each header field sent, the length field with its parity result, each received data byte, and faults. The sequencer turns these events into sticky flags. It also drives two interrupts and a per-byte transfer request for a DMA engine. That request stops once the programmed number of bytes has been moved.

The controller runs in the states `ST_IDLE`, `ST_WAIT_SLV`, `ST_ARB`, `ST_HDR`, `ST_LEN` and `ST_DATA`.
- A command in `ST_IDLE` goes to `ST_ARB`. If slave reception is in progress, it goes to `ST_WAIT_SLV` instead.
- `ST_WAIT_SLV` goes to `ST_ARB` when slave reception ends.
- `ST_ARB` goes to `ST_HDR` on a win. It goes to `ST_IDLE` on a loss or a transmit fault.
- `ST_HDR` goes to `ST_LEN` after its third field. It goes to `ST_IDLE` on a transmit fault.
- `ST_LEN` goes to `ST_DATA` on good parity. It goes to `ST_IDLE` on bad parity or a receive fault.
- `ST_DATA` goes to `ST_IDLE` on the last byte or on a receive fault.

Top module: `mrx_status_seq`

## Requirements
- R1: After reset all flags, `xfer_en`, `xfer_req`, both interrupts and `tx_err_code` are 0.
- R2: `exec_busy` follows `slave_rx_busy` one cycle late. A command given while `slave_rx_busy` is 1 leaves `mreq_flag` at 0. `mreq_flag` becomes 1 on the first clock edge that sees `slave_rx_busy` at 0.
- R3: `arb_lost` while arbitrating sets `arb_lost_flag`, clears `mreq_flag` and returns to idle.
- R4: `tx_fault` during arbitration or before the third `hdr_step` sets `tx_err_flag`, latches `tx_fault_code` into `tx_err_code` and clears `mreq_flag`. `tx_fault` after the header has no effect.
- R5: `len_rcvd` with `len_parity_err`=1 sets `rx_err_flag`, leaves `rx_start_flag` at 0 and clears `mreq_flag`.
- R6: `len_rcvd` with good parity sets `rx_start_flag`. `rx_status_irq` is the OR of `rx_start_flag`, `norm_done_flag`, and `rx_err_flag` gated by `rxe_int_en`.
- R7: Each data byte sets `byte_rdy_flag`. A `rbuf_rd` strobe clears it.
- R8: While `xfer_en` is 1, each data byte gives a one-cycle `xfer_req`. `xfer_en` is set by `xfer_en_set` and cleared on the byte that reaches `xfer_count` (0 counts as 1). `byte_rdy_irq` = `byte_rdy_flag` AND NOT `xfer_en`.
- R9: The byte that reaches the count sets `norm_done_flag`, clears `mreq_flag` and returns to idle. `byte_rdy_flag` stays set.
- R10: `rx_err_flag` raises `rx_status_irq` only when `rxe_int_en` is 1.
- R11: `clr_wr` clears each flag whose `clr_mask` bit is 1. The bits are 0 rx_start, 1 byte_rdy, 2 norm_done, 3 rx_err, 4 tx_err, 5 arb_lost. A hardware set in the same cycle wins.
- R12: `cmd_start` outside idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Master request command write |
| slave_rx_busy | input | 1 | Slave reception in progress |
| arb_won | input | 1 | Arbitration won |
| arb_lost | input | 1 | Arbitration lost |
| hdr_step | input | 1 | One header field sent |
| tx_fault | input | 1 | Transmit-side fault |
| tx_fault_code | input | 4 | Fault code for tx_fault |
| len_rcvd | input | 1 | Length field received |
| len_parity_err | input | 1 | Length parity bad |
| data_rcvd | input | 1 | Data byte received |
| rx_fault | input | 1 | Receive-side fault |
| rbuf_rd | input | 1 | Receive buffer read strobe |
| clr_wr | input | 1 | Flag clear write |
| clr_mask | input | 6 | Flags to clear |
| xfer_en_set | input | 1 | Sets transfer enable |
| xfer_count | input | 8 | Programmed byte count |
| rxe_int_en | input | 1 | Receive-error interrupt enable |
| exec_busy | output | 1 | Command-execution flag |
| mreq_flag | output | 1 | Master request active |
| rx_start_flag | output | 1 | Receive start seen |
| byte_rdy_flag | output | 1 | Byte ready |
| norm_done_flag | output | 1 | Normal completion |
| rx_err_flag | output | 1 | Receive error |
| tx_err_flag | output | 1 | Transmit error |
| arb_lost_flag | output | 1 | Arbitration lost |
| tx_err_code | output | 4 | Latched fault code |
| rx_status_irq | output | 1 | Receive-status interrupt |
| byte_rdy_irq | output | 1 | Byte-ready interrupt |
| xfer_req | output | 1 | Per-byte transfer request |
| xfer_en | output | 1 | Transfer enable bit |

## Verification
Directed sequences cover each way a transaction can end: a lost arbitration, a fault inside the header, bad length parity, and a normal finish. Each of these tells apart which flag, if any, is set and whether `mreq_flag` drops. Randomized transactions vary the byte count from 1 to 6, the gaps between bytes and buffer reads placed in those gaps. They separate an off-by-one in the byte counter from a request that is missing or one too many. A clear write landing on a new byte shows whether the hardware set wins over the clear.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SLV,
        ST_ARB,
        ST_HDR,
        ST_LEN,
        ST_DATA
    } mrx_state_t;

    localparam int NFLAG   = 6;
    localparam int F_RXS   = 0;
    localparam int F_BRDY  = 1;
    localparam int F_NORM  = 2;
    localparam int F_RXE   = 3;
    localparam int F_TXE   = 4;
    localparam int F_ARBL  = 5;
endpackage

// File: rtl/mrx_flag_bank.sv
module mrx_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_o[g] <= 1'b0;
            else if (set_i[g]) flag_o[g] <= 1'b1;
            else if (clr_i[g]) flag_o[g] <= 1'b0;
        end
    end

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/mrx_byte_cnt.sv
module mrx_byte_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rem <= '0;
        else if (load)  rem <= (load_val == '0) ? CNT_W'(1) : load_val;
        else if (dec)   rem <= rem - 1'b1;
    end

    assign last = (rem == CNT_W'(1));

    // R8
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (rem != '0));
endmodule

// File: rtl/mrx_status_seq.sv
module mrx_status_seq
    import mrx_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int CODE_W     = 4,
    parameter int HDR_FIELDS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              slave_rx_busy,
    input  logic              arb_won,
    input  logic              arb_lost,
    input  logic              hdr_step,
    input  logic              tx_fault,
    input  logic [CODE_W-1:0] tx_fault_code,
    input  logic              len_rcvd,
    input  logic              len_parity_err,
    input  logic              data_rcvd,
    input  logic              rx_fault,
    input  logic              rbuf_rd,
    input  logic              clr_wr,
    input  logic [5:0]        clr_mask,
    input  logic              xfer_en_set,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic              rxe_int_en,
    output logic              exec_busy,
    output logic              mreq_flag,
    output logic              rx_start_flag,
    output logic              byte_rdy_flag,
    output logic              norm_done_flag,
    output logic              rx_err_flag,
    output logic              tx_err_flag,
    output logic              arb_lost_flag,
    output logic [CODE_W-1:0] tx_err_code,
    output logic              rx_status_irq,
    output logic              byte_rdy_irq,
    output logic              xfer_req,
    output logic              xfer_en
);
    localparam int HW = $clog2(HDR_FIELDS + 1);

    mrx_state_t state, state_nx;
    logic [HW-1:0] hdr_cnt;
    logic [NFLAG-1:0] set_vec, clr_vec, flags;
    logic cnt_last, len_ok, byte_evt, last_evt, tx_abort, go_arb;

    // event decode
    always_comb begin
        go_arb   = (state == ST_IDLE && cmd_start && !slave_rx_busy) ||
                   (state == ST_WAIT_SLV && !slave_rx_busy);
        tx_abort = (state == ST_ARB || state == ST_HDR) && tx_fault;
        len_ok   = (state == ST_LEN) && !rx_fault && len_rcvd && !len_parity_err;
        byte_evt = (state == ST_DATA) && !rx_fault && data_rcvd;
        last_evt = byte_evt && cnt_last;

        set_vec         = '0;
        set_vec[F_RXS]  = len_ok;
        set_vec[F_BRDY] = byte_evt;
        set_vec[F_NORM] = last_evt;
        set_vec[F_RXE]  = ((state == ST_LEN) && (rx_fault || (len_rcvd && len_parity_err))) ||
                          ((state == ST_DATA) && rx_fault);
        set_vec[F_TXE]  = tx_abort;
        set_vec[F_ARBL] = (state == ST_ARB) && !tx_fault && arb_lost;

        clr_vec         = clr_wr ? clr_mask[NFLAG-1:0] : '0;
        clr_vec[F_BRDY] = clr_vec[F_BRDY] | rbuf_rd;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (cmd_start) state_nx = slave_rx_busy ? ST_WAIT_SLV : ST_ARB;
            ST_WAIT_SLV: if (!slave_rx_busy) state_nx = ST_ARB;
            ST_ARB:      if (tx_fault || arb_lost) state_nx = ST_IDLE;
                         else if (arb_won) state_nx = ST_HDR;
            ST_HDR:      if (tx_fault) state_nx = ST_IDLE;
                         else if (hdr_step && hdr_cnt == HW'(HDR_FIELDS - 1)) state_nx = ST_LEN;
            ST_LEN:      if (rx_fault || len_rcvd) state_nx = len_ok ? ST_DATA : ST_IDLE;
            ST_DATA:     if (rx_fault || last_evt) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_busy   <= 1'b0;
            mreq_flag   <= 1'b0;
            hdr_cnt     <= '0;
            tx_err_code <= '0;
            xfer_req    <= 1'b0;
            xfer_en     <= 1'b0;
        end else begin
            exec_busy <= slave_rx_busy;
            if (go_arb)                                        mreq_flag <= 1'b1;
            else if (state_nx == ST_IDLE && state != ST_IDLE)  mreq_flag <= 1'b0;
            if (state != ST_HDR)                               hdr_cnt <= '0;
            else if (hdr_step)                                 hdr_cnt <= hdr_cnt + 1'b1;
            if (tx_abort)                                      tx_err_code <= tx_fault_code;
            xfer_req <= byte_evt && xfer_en;
            if (last_evt)         xfer_en <= 1'b0;
            else if (xfer_en_set) xfer_en <= 1'b1;
        end
    end

    mrx_flag_bank #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .flag_o(flags)
    );

    mrx_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(len_ok), .load_val(xfer_count),
        .dec(byte_evt), .last(cnt_last)
    );

    assign rx_start_flag  = flags[F_RXS];
    assign byte_rdy_flag  = flags[F_BRDY];
    assign norm_done_flag = flags[F_NORM];
    assign rx_err_flag    = flags[F_RXE];
    assign tx_err_flag    = flags[F_TXE];
    assign arb_lost_flag  = flags[F_ARBL];
    assign rx_status_irq  = rx_start_flag | norm_done_flag | (rx_err_flag & rxe_int_en);
    assign byte_rdy_irq   = byte_rdy_flag & ~xfer_en;

    // R2
    mreq_after_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mreq_flag) |-> !$past(slave_rx_busy));
    // R8
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> $past(xfer_en));
    // R9
    done_drops_mreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(norm_done_flag) |-> !mreq_flag);
    // R5
    rxs_good_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_start_flag) |-> !$past(len_parity_err));
    // R3
    arb_loss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost_flag) |-> !mreq_flag);
endmodule

// File: tb/mrx_status_seq_test.sv
module mrx_status_seq_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_start = 0, slave_rx_busy = 0, arb_won = 0, arb_lost = 0, hdr_step = 0, tx_fault = 0;
    logic [3:0] tx_fault_code = 0;
    logic len_rcvd = 0, len_parity_err = 0, data_rcvd = 0, rx_fault = 0, rbuf_rd = 0, clr_wr = 0;
    logic [5:0] clr_mask = 0;
    logic xfer_en_set = 0, rxe_int_en = 0;
    logic [7:0] xfer_count = 0;
    logic exec_busy, mreq_flag, rx_start_flag, byte_rdy_flag, norm_done_flag, rx_err_flag;
    logic tx_err_flag, arb_lost_flag, rx_status_irq, byte_rdy_irq, xfer_req, xfer_en;
    logic [3:0] tx_err_code;
    int total = 0, fails = 0;

    always #5 clk = ~clk;

    mrx_status_seq uut (.*);

    function automatic logic exp_irq(logic rs, logic nd, logic re, logic en);
        return rs | nd | (re & en);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        cmd_start = 0; arb_won = 0; arb_lost = 0; hdr_step = 0; tx_fault = 0;
        len_rcvd = 0; len_parity_err = 0; data_rcvd = 0; rx_fault = 0;
        rbuf_rd = 0; clr_wr = 0; clr_mask = 0; xfer_en_set = 0;
    endtask

    task automatic run_header();
        cmd_start = 1; tick();
        arb_won = 1; tick();
        for (int i = 0; i < 3; i++) begin hdr_step = 1; tick(); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1 flags", {mreq_flag, rx_start_flag, byte_rdy_flag, norm_done_flag, rx_err_flag,
                         tx_err_flag, arb_lost_flag, xfer_en, xfer_req, rx_status_irq, byte_rdy_irq}, 0);
        chk("R1 code", tx_err_code, 0);

        // R2 command held off by slave reception
        slave_rx_busy = 1; tick();
        cmd_start = 1; tick();
        chk("R2 exec_busy", exec_busy, 1);
        chk("R2 mreq held", mreq_flag, 0);
        tick(); tick();
        chk("R2 mreq still held", mreq_flag, 0);
        slave_rx_busy = 0; tick();
        chk("R2 mreq set", mreq_flag, 1);
        tick();
        chk("R2 exec_busy clear", exec_busy, 0);

        // R3 arbitration lost
        arb_lost = 1; tick();
        chk("R3 arb flag", arb_lost_flag, 1);
        chk("R3 mreq", mreq_flag, 0);
        clr_wr = 1; clr_mask = 6'b100000; tick();
        chk("R11 clr arb", arb_lost_flag, 0);

        // R4 fault inside header
        cmd_start = 1; tick();
        arb_won = 1; tick();
        hdr_step = 1; tick();
        tx_fault = 1; tx_fault_code = 4'h5; tick();
        chk("R4 tx_err", tx_err_flag, 1);
        chk("R4 code", tx_err_code, 5);
        chk("R4 mreq", mreq_flag, 0);
        clr_wr = 1; clr_mask = 6'b010000; tick();

        // R5 bad length parity, R10 gating
        rxe_int_en = 0;
        run_header();
        len_rcvd = 1; len_parity_err = 1; tick();
        chk("R5 rx_err", rx_err_flag, 1);
        chk("R5 no rx_start", rx_start_flag, 0);
        chk("R5 mreq", mreq_flag, 0);
        chk("R10 irq gated", rx_status_irq, 0);
        rxe_int_en = 1; #1;
        chk("R10 irq enabled", rx_status_irq, 1);
        clr_wr = 1; clr_mask = 6'b001000; tick();

        // main transfer of 3 bytes
        xfer_count = 3; xfer_en_set = 1; tick();
        chk("R8 en set", xfer_en, 1);
        run_header();
        len_rcvd = 1; tick();
        chk("R6 rx_start", rx_start_flag, 1);
        chk("R6 irq", rx_status_irq, 1);
        tx_fault = 1; tx_fault_code = 4'h9; tick();
        chk("R4 late fault ignored", tx_err_flag, 0);
        cmd_start = 1; tick();
        chk("R12 mreq kept", mreq_flag, 1);
        data_rcvd = 1; clr_wr = 1; clr_mask = 6'b000010; tick();
        chk("R11 set wins", byte_rdy_flag, 1);
        chk("R8 req byte1", xfer_req, 1);
        rbuf_rd = 1; tick();
        chk("R7 read clears", byte_rdy_flag, 0);
        chk("R8 req pulse", xfer_req, 0);
        clr_wr = 1; clr_mask = 6'b000001; tick();
        chk("R6 irq off", rx_status_irq, 0);
        data_rcvd = 1; tick();
        chk("R8 req byte2", xfer_req, 1);
        chk("R9 not done", norm_done_flag, 0);
        data_rcvd = 1; tick();
        chk("R8 req last", xfer_req, 1);
        chk("R8 en cleared", xfer_en, 0);
        chk("R9 done", norm_done_flag, 1);
        chk("R9 mreq", mreq_flag, 0);
        chk("R9 byte_rdy kept", byte_rdy_flag, 1);
        chk("R8 byte irq", byte_rdy_irq, 1);
        chk("R9 irq", rx_status_irq, exp_irq(0, 1, 0, 1));
        data_rcvd = 1; tick();
        chk("R8 no req after count", xfer_req, 0);
        rbuf_rd = 1; clr_wr = 1; clr_mask = 6'h3f; tick();

        // random transactions
        for (int t = 0; t < 20; t++) begin
            int n;
            n = 1 + int'($urandom % 6);
            xfer_count = 8'(n); xfer_en_set = 1; tick();
            run_header();
            len_rcvd = 1; tick();
            for (int b = 0; b < n; b++) begin
                int gap;
                gap = int'($urandom % 3);
                for (int g = 0; g < gap; g++) begin
                    rbuf_rd = 1'($urandom % 2); tick();
                end
                data_rcvd = 1; tick();
                chk("R8 rand req", xfer_req, 1);
                chk("R7 rand byte_rdy", byte_rdy_flag, 1);
                chk("R9 rand done", norm_done_flag, (b == n - 1) ? 1 : 0);
            end
            chk("R8 rand en off", xfer_en, 0);
            chk("R9 rand mreq", mreq_flag, 0);
            chk("R6 rand irq", rx_status_irq, exp_irq(1, 1, 0, rxe_int_en));
            rbuf_rd = 1; clr_wr = 1; clr_mask = 6'h3f; tick();
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule